// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each data beat of a single read or write burst in a double-data-rate memory controller or memory model. A one-cycle start pulse captures a starting column, a burst-length code and an ordering mode. From the next clock onward the block presents one column address per cycle, together with a valid flag and a flag that marks the final beat.

Every address of a burst lies inside an aligned block whose size equals the burst length. The column bits above that block stay fixed for the whole burst. Only the low offset bits are permuted. In wrapping order they count up from the start offset and roll over to zero at the block edge. In interleaved order they are the start offset XOR the beat index.

A start that arrives on the final beat opens the next burst with no idle cycle. A start that arrives at any other point of a running burst is dropped. A reserved length code yields no beats and raises an error flag instead.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and with no start applied, `col_o`, `valid_o`, `last_o`, `busy_o` and `err_o` are all 0.
- R2: An accepted start with `len_code_i` of 0, 1 or 2 gives a burst of 2, 4 or 8 beats. `valid_o` is high on exactly that many consecutive cycles, beginning on the cycle after the start edge, and the first beat carries the starting column unchanged.
- R3: `last_o` is high only on the final beat of a burst. `valid_o` is low on the cycle after the final beat unless a new burst was accepted on that beat.
- R4: With `ilv_i` = 0 (wrapping order), the low offset on beat k is (start offset + k) modulo the burst length.
- R5: With `ilv_i` = 1 (interleaved order), the low offset on beat k is the start offset XOR k.
- R6: The column bits from bit log2(burst length) upward equal those of the starting column on every beat.
- R7: A start presented on the final beat is accepted, and its first beat appears on the very next cycle.
- R8: `busy_o` is high while a burst runs. A start presented during a burst, on any beat but the last, is ignored and causes no extra beats.
- R9: `len_code_i` = 3 is reserved. An accepted start with that code produces no beats, and it drives `err_o` high for exactly the one cycle after the start edge.
- R10: Column, length and order are sampled only on an accepted start. Changes on those inputs during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a burst |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 2 | Burst length: 0 = 2, 1 = 4, 2 = 8, 3 = reserved |
| ilv_i | input | 1 | Ordering: 0 = wrapping, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat, 0 when idle |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat of the burst |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | Pulse after a start with the reserved length code |

## Verification
The bench sweeps every start offset against every length and both orders. A sequencer that wraps at the wrong block size, or that mixes up XOR and addition, therefore gives a wrong column on some beat. It also sets the column bits just above the offset field, so that a carry leaking out of the block would show up as a changed upper bit. Other tests pulse start on the final beat and in the middle of a burst: a design that inserts a bubble leaves a gap where beats are expected, and a design that restarts mid-burst emits beats the scoreboard does not expect. A reserved length code is tried both from idle and on a final beat, so a design that runs anyway or leaves the error flag stuck is caught.

// File: rtl/bsq_pkg.sv
// Package: shared types and helpers for the burst column sequencer.
// Assumes at most eight beats per burst, so the offset field is three bits wide.
package bsq_pkg;

    localparam int OFS_W = 3;

    // Burst-length code as presented on the start interface
    typedef enum logic [1:0] {
        BL_TWO   = 2'd0,
        BL_FOUR  = 2'd1,
        BL_EIGHT = 2'd2,
        BL_RSVD  = 2'd3
    } bl_code_e;

    // Offset mask for a length code; the reserved code maps to zero
    function automatic logic [OFS_W-1:0] code_mask(input logic [1:0] code);
        logic [OFS_W-1:0] m;
        case (code)
            BL_TWO:   m = 3'b001;
            BL_FOUR:  m = 3'b011;
            BL_EIGHT: m = 3'b111;
            default:  m = 3'b000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bsq_ctrl.sv
// Module: bsq_ctrl
// Accepts start requests, captures the burst parameters and steps a beat
// counter through one burst. Assumes the caller holds start_i for one cycle
// per request. Reports last beat, the captured mask and base, and an error
// pulse for the reserved length code.
module bsq_ctrl
    import bsq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_code_i,
    input  logic             ilv_i,
    output logic             active_o,
    output logic [OFS_W-1:0] beat_o,
    output logic             last_o,
    output logic [OFS_W-1:0] mask_o,
    output logic [COL_W-1:0] base_o,
    output logic             ilv_o,
    output logic             err_o
);

    logic             active_q;
    logic [OFS_W-1:0] beat_q;
    logic [OFS_W-1:0] mask_q;
    logic [COL_W-1:0] base_q;
    logic             ilv_q;
    logic             err_q;
    logic             final_beat;
    logic             accept;
    logic             legal;

    // Decode the final beat, acceptance window and code legality
    always_comb begin
        final_beat = active_q && (beat_q == mask_q);
        accept     = start_i && (!active_q || final_beat);
        legal      = (len_code_i != BL_RSVD);
    end

    // Capture burst parameters on accept, advance or finish otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            ilv_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= accept && !legal;
            if (accept && legal) begin
                active_q <= 1'b1;
                beat_q   <= '0;
                mask_q   <= code_mask(len_code_i);
                base_q   <= start_col_i;
                ilv_q    <= ilv_i;
            end else if (active_q) begin
                if (final_beat) begin
                    active_q <= 1'b0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    // Drive outputs from state
    always_comb begin
        active_o = active_q;
        beat_o   = beat_q;
        last_o   = final_beat;
        mask_o   = mask_q;
        base_o   = base_q;
        ilv_o    = ilv_q;
        err_o    = err_q;
    end

    assert_beat_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (beat_q <= mask_q));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && legal) |=> (active_q && beat_q == '0));

    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !final_beat) |=> active_q);

    assert_mid_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_q && !final_beat) |=> ($stable(base_q) && $stable(mask_q)));

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !active_q);

endmodule

// File: rtl/bsq_permute.sv
// Module: bsq_permute
// Combinational offset generator. Takes the captured start offset, the beat
// index and the block mask, and returns the offset for the beat in wrapping
// or interleaved order. Assumes beat_i never exceeds mask_i.
module bsq_permute
    import bsq_pkg::*;
(
    input  logic [OFS_W-1:0] start_ofs_i,
    input  logic [OFS_W-1:0] beat_i,
    input  logic [OFS_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [OFS_W-1:0] ofs_o
);

    logic [OFS_W-1:0] wrap_ofs;
    logic [OFS_W-1:0] xor_ofs;

    // Form both orderings and keep only the bits inside the block
    always_comb begin
        wrap_ofs = (start_ofs_i + beat_i) & mask_i;
        xor_ofs  = (start_ofs_i ^ beat_i) & mask_i;
        ofs_o    = ilv_i ? xor_ofs : wrap_ofs;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Emits one column address per beat for a burst of 2, 4 or 8 beats. Bits
// inside the aligned block come from the offset generator; bits above it come
// from the captured start column. Assumes COL_W is wider than the offset field.
module burst_col_seq
    import bsq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             err_o
);

    localparam int HI_W = COL_W - OFS_W;

    logic             active;
    logic [OFS_W-1:0] beat;
    logic             final_beat;
    logic [OFS_W-1:0] mask;
    logic [COL_W-1:0] base;
    logic             ilv;
    logic             err;
    logic [OFS_W-1:0] ofs;
    logic [COL_W-1:0] merged;

    bsq_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .active_o    (active),
        .beat_o      (beat),
        .last_o      (final_beat),
        .mask_o      (mask),
        .base_o      (base),
        .ilv_o       (ilv),
        .err_o       (err)
    );

    bsq_permute perm_i (
        .start_ofs_i (base[OFS_W-1:0]),
        .beat_i      (beat),
        .mask_i      (mask),
        .ilv_i       (ilv),
        .ofs_o       (ofs)
    );

    // Per-bit merge: offset bits where the mask is set, base bits elsewhere
    for (genvar b = 0; b < OFS_W; b++) begin : g_low
        always_comb merged[b] = mask[b] ? ofs[b] : base[b];
    end
    // Upper bits always follow the captured base
    always_comb merged[COL_W-1:OFS_W] = base[COL_W-1:OFS_W];

    // Drive ports, zeroing the column when idle
    always_comb begin
        col_o   = active ? merged : '0;
        valid_o = active;
        last_o  = final_beat;
        busy_o  = active;
        err_o   = err;
    end

    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W])));

    assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    assert_err_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    initial assert_width_ok: assert (HI_W > 0);

endmodule

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, busy_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        logic [COL_W-1:0] start;
        int               bl;
        string            tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                                 input int bl, input bit ilv, input int k);
        int o, n;
        o = int'(s) & (bl - 1);
        n = ilv ? (o ^ k) : ((o + k) % bl);
        return (s & ~COL_W'(bl - 1)) | COL_W'(n);
    endfunction

    // Driver: present a start and queue the expected beats (caller owns timing)
    task automatic drive_start(input logic [COL_W-1:0] col, input int code,
                               input bit ilv, input string tag);
        start_i     = 1'b1;
        start_col_i = col;
        len_code_i  = code[1:0];
        ilv_i       = ilv;
        if (code < 3) begin
            int bl = 2 << code;
            for (int k = 0; k < bl; k++) begin
                exp_t e;
                e.col   = exp_col(col, bl, ilv, k);
                e.last  = (k == bl - 1);
                e.start = col;
                e.bl    = bl;
                e.tag   = (tag != "") ? tag : (ilv ? "R5" : "R4");
                sb.push_back(e);
            end
        end
    endtask

    task automatic drop_start();
        start_i     = 1'b0;
        start_col_i = ~start_col_i;
        len_code_i  = len_code_i + 2'd1;
        ilv_i       = ~ilv_i;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        chk(sb.size() == 0, "R2", "beats missing at burst end", sb.size(), 0);
        chk(valid_o == 1'b0, "R3", "valid after final beat", valid_o, 0);
    endtask

    task automatic one_burst(input logic [COL_W-1:0] col, input int code, input bit ilv);
        @(negedge clk);
        drive_start(col, code, ilv, "");
        @(negedge clk);
        drop_start();
        wait_idle();
    endtask

    // Monitor: pop and compare every presented beat
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected beat", col_o, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(col_o == e.col, e.tag, "column", col_o, e.col);
                chk(last_o == e.last, "R3", "last flag", last_o, e.last);
                chk((col_o & ~COL_W'(e.bl - 1)) == (e.start & ~COL_W'(e.bl - 1)),
                    "R6", "upper bits", col_o, e.start);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(col_o == '0 && !valid_o && !last_o && !busy_o && !err_o,
            "R1", "reset outputs", {col_o, valid_o, last_o, busy_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !busy_o && !err_o, "R1", "idle after reset",
            {valid_o, busy_o, err_o}, 0);

        // R4 and R5 named cases
        one_burst(10'h2A5, 2, 1'b0);
        one_burst(10'h2A5, 2, 1'b1);
        one_burst(10'h1F2, 1, 1'b1);

        // R2: first beat equals start column
        @(negedge clk);
        drive_start(10'h0B7, 2, 1'b1, "");
        @(negedge clk);
        drop_start();
        chk(valid_o && col_o == 10'h0B7, "R2", "first beat column", col_o, 10'h0B7);
        wait_idle();

        // Sweep every length, order and offset; upper bits set to catch carries
        for (int code = 0; code < 3; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int o = 0; o < 8; o++)
                    one_burst({7'h55, 3'(o)}, code, ilv[0]);

        // R7: back-to-back on final beat
        @(negedge clk);
        drive_start(10'h3C6, 1, 1'b0, "");
        @(negedge clk);
        drop_start();
        while (!last_o) @(negedge clk);
        drive_start(10'h141, 0, 1'b1, "R7");
        @(negedge clk);
        drop_start();
        chk(valid_o == 1'b1, "R7", "no gap between bursts", valid_o, 1);
        chk(col_o == 10'h141, "R7", "second burst first column", col_o, 10'h141);
        wait_idle();

        // R8: start mid-burst is ignored
        @(negedge clk);
        drive_start(10'h013, 2, 1'b0, "");
        @(negedge clk);
        drop_start();
        repeat (2) @(negedge clk);
        chk(busy_o == 1'b1, "R8", "busy during burst", busy_o, 1);
        start_i = 1'b1; start_col_i = 10'h3FF; len_code_i = 2'd0; ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R10: inputs wander during a burst without start
        @(negedge clk);
        drive_start(10'h2EC, 2, 1'b1, "R10");
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            start_col_i = 10'(i * 97);
            len_code_i  = 2'(i);
            ilv_i       = i[0];
            @(negedge clk);
        end
        wait_idle();

        // R9: reserved code from idle
        @(negedge clk);
        drive_start(10'h100, 3, 1'b0, "");
        @(negedge clk);
        drop_start();
        chk(err_o == 1'b1, "R9", "error pulse", err_o, 1);
        chk(valid_o == 1'b0, "R9", "no beat on reserved code", valid_o, 0);
        @(negedge clk);
        chk(err_o == 1'b0, "R9", "error pulse one cycle", err_o, 0);
        chk(busy_o == 1'b0, "R9", "stays idle", busy_o, 0);

        // R9: reserved code on a final beat ends activity
        drive_start(10'h0A0, 0, 1'b0, "");
        @(negedge clk);
        drop_start();
        while (!last_o) @(negedge clk);
        drive_start(10'h0A0, 3, 1'b1, "");
        @(negedge clk);
        drop_start();
        chk(err_o == 1'b1 && valid_o == 1'b0, "R9", "reserved on final beat",
            {err_o, valid_o}, 2);
        wait_idle();

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule